// File: doc/BRIEF.md
# Distance-Aware Transmit Power Selector

This block picks the drive-strength code for a transmitter that talks to several receiver layers stacked at different distances above it. A small register file keeps one minimum-adequate level code per destination layer. Software or a configuration engine loads it through a one-cycle write port. Layer 0 is the nearest destination and the highest layer index is the farthest.

When a transfer starts, the block looks at the target layer and a broadcast flag and registers the level code for the whole burst. A unicast transfer uses the code of its layer. A broadcast uses the code of the farthest layer, because every layer must hear it. An index that names no layer gets full strength and an error flag. Between transfers the level output is 0, which means the transmitter is off, so the level can change freely from one transfer to the next.

Level changes only happen at transfer boundaries. A write to the register that the running transfer was drawn from is held back until that transfer ends. The block also flags a register file whose codes fall anywhere from a nearer layer to a farther one.

Top module: `txlvl_sel`

## Requirements
- R1: After reset every layer register holds 15, `level_o` is 0, and `busy_o`, `idx_err_o` and `order_err_o` are low.
- R2: A start accepted while idle (`req_start_i` high, `busy_o` low, `req_bcast_i` low, `req_layer_i` below 4) raises `busy_o` and drives `level_o` to the chosen layer's code on the following cycle.
- R3: A broadcast start uses the code of layer 3 (the farthest layer), whatever the layer index is, and leaves `idx_err_o` low.
- R4: A non-broadcast start with `req_layer_i` from 4 to 7 drives `level_o` to 15 and holds `idx_err_o` high for that transfer.
- R5: While `busy_o` is high, `level_o` stays constant. A `req_start_i` pulse during a transfer is ignored.
- R6: `req_end_i` while busy makes `busy_o` fall and returns `level_o` and `idx_err_o` to 0 on the next cycle.
- R7: `order_err_o` is high exactly when some layer's code is larger than the code of the next higher layer. Equal neighbours are allowed.
- R8: A write to a layer register other than the one the current transfer uses takes effect on the next cycle, busy or not.
- R9: A write to the register the current transfer uses is deferred and is applied at the clock edge that ends the transfer. The last such write wins, and this includes a write in the same cycle as `req_end_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for a layer register |
| cfg_layer_i | input | 2 | Layer register to write |
| cfg_code_i | input | 4 | Level code to write (0 = off, 1..15 = strength) |
| req_start_i | input | 1 | Transfer start, taken only while idle |
| req_layer_i | input | 3 | Destination layer of the transfer |
| req_bcast_i | input | 1 | Transfer goes to all layers |
| req_end_i | input | 1 | Last cycle of the running transfer |
| level_o | output | 4 | Registered drive-level code |
| busy_o | output | 1 | Transfer in progress |
| idx_err_o | output | 1 | Current transfer named a nonexistent layer |
| order_err_o | output | 1 | Programmed codes do not rise from the near layer to the far layer |

## Verification
The assertions assume that the driver raises `req_start_i` only while `busy_o` is low, except on purpose to show the pulse is ignored. They also assume that `req_end_i` comes only during a transfer, and that a write never hits the selected layer in the same cycle as the start that reads it. The stimulus follows these rules: a start is held for one cycle, and the end is driven at least one cycle after it. Configuration writes during a burst are placed in the middle cycles or on the end cycle, never on the start cycle.

// File: rtl/txlvl_pkg.sv
package txlvl_pkg;
  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_BUSY = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/txlvl_regfile.sv
module txlvl_regfile #(
  parameter int NUM_LAYERS = 4,
  parameter int CODE_W     = 4,
  localparam int LSEL_W    = $clog2(NUM_LAYERS),
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}}
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [LSEL_W-1:0]                  wr_layer_i,
  input  logic [CODE_W-1:0]                  wr_code_i,
  input  logic                               busy_i,
  input  logic                               act_v_i,
  input  logic [LSEL_W-1:0]                  act_layer_i,
  input  logic                               xfer_end_i,
  output logic [NUM_LAYERS-1:0][CODE_W-1:0]  codes_o,
  output logic                               order_err_o
);
  logic              hit;
  logic              commit;
  logic [CODE_W-1:0] commit_code;
  logic              pend_v_q;
  logic [CODE_W-1:0] pend_code_q;

  // write aimed at the register the running burst came from
  assign hit         = we_i & busy_i & act_v_i & (wr_layer_i == act_layer_i);
  assign commit      = xfer_end_i & (pend_v_q | hit);
  assign commit_code = hit ? wr_code_i : pend_code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_code_q <= '0;
    end else if (xfer_end_i) begin
      pend_v_q    <= 1'b0;
    end else if (hit) begin
      pend_v_q    <= 1'b1;
      pend_code_q <= wr_code_i;
    end
  end

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= MAX_CODE;
      end else if (commit && act_layer_i == LSEL_W'(g)) begin
        code_q <= commit_code;
      end else if (we_i && !hit && wr_layer_i == LSEL_W'(g)) begin
        code_q <= wr_code_i;
      end
    end
    assign codes_o[g] = code_q;
  end

  always_comb begin
    order_err_o = 1'b0;
    for (int i = 0; i < NUM_LAYERS - 1; i++) begin
      if (codes_o[i] > codes_o[i+1]) order_err_o = 1'b1;
    end
  end
endmodule

// File: rtl/txlvl_pick.sv
module txlvl_pick #(
  parameter int NUM_LAYERS = 4,
  parameter int CODE_W     = 4,
  parameter int IDX_W      = 3,
  localparam int LSEL_W    = $clog2(NUM_LAYERS),
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}}
) (
  input  logic [NUM_LAYERS-1:0][CODE_W-1:0] codes_i,
  input  logic [IDX_W-1:0]                  layer_i,
  input  logic                              bcast_i,
  output logic [CODE_W-1:0]                 level_o,
  output logic                              err_o,
  output logic                              src_v_o,
  output logic [LSEL_W-1:0]                 src_layer_o
);
  logic oor;
  assign oor = int'(layer_i) >= NUM_LAYERS;

  always_comb begin
    level_o     = MAX_CODE;
    err_o       = 1'b0;
    src_v_o     = 1'b0;
    src_layer_o = '0;
    if (bcast_i) begin
      // every layer must hear it: farthest layer sets the level
      src_layer_o = LSEL_W'(NUM_LAYERS - 1);
      src_v_o     = 1'b1;
      level_o     = codes_i[NUM_LAYERS-1];
    end else if (oor) begin
      err_o       = 1'b1;
    end else begin
      src_layer_o = layer_i[LSEL_W-1:0];
      src_v_o     = 1'b1;
      level_o     = codes_i[layer_i[LSEL_W-1:0]];
    end
  end
endmodule

// File: rtl/txlvl_hold.sv
module txlvl_hold
  import txlvl_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int CODE_W     = 4,
  localparam int LSEL_W    = $clog2(NUM_LAYERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              xfer_end_i,
  input  logic [CODE_W-1:0] pick_level_i,
  input  logic              pick_err_i,
  input  logic              pick_src_v_i,
  input  logic [LSEL_W-1:0] pick_src_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] level_o,
  output logic              idx_err_o,
  output logic              act_v_o,
  output logic [LSEL_W-1:0] act_layer_o
);
  xfer_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= XF_IDLE;
      level_o     <= '0;
      idx_err_o   <= 1'b0;
      act_v_o     <= 1'b0;
      act_layer_o <= '0;
    end else if (state_q == XF_IDLE && start_i) begin
      state_q     <= XF_BUSY;
      level_o     <= pick_level_i;
      idx_err_o   <= pick_err_i;
      act_v_o     <= pick_src_v_i;
      act_layer_o <= pick_src_i;
    end else if (xfer_end_i) begin
      state_q     <= XF_IDLE;
      level_o     <= '0;
      idx_err_o   <= 1'b0;
      act_v_o     <= 1'b0;
    end
  end

  assign busy_o = (state_q == XF_BUSY);
endmodule

// File: rtl/txlvl_sel.sv
module txlvl_sel #(
  parameter int NUM_LAYERS = 4,
  parameter int CODE_W     = 4,
  parameter int IDX_W      = 3,
  localparam int LSEL_W    = $clog2(NUM_LAYERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LSEL_W-1:0] cfg_layer_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              req_start_i,
  input  logic [IDX_W-1:0]  req_layer_i,
  input  logic              req_bcast_i,
  input  logic              req_end_i,
  output logic [CODE_W-1:0] level_o,
  output logic              busy_o,
  output logic              idx_err_o,
  output logic              order_err_o
);
  logic [NUM_LAYERS-1:0][CODE_W-1:0] codes_w;
  logic [CODE_W-1:0] pick_level;
  logic              pick_err;
  logic              pick_src_v;
  logic [LSEL_W-1:0] pick_src;
  logic              act_v;
  logic [LSEL_W-1:0] act_layer;
  logic              xfer_end;

  assign xfer_end = busy_o & req_end_i;

  txlvl_regfile #(.NUM_LAYERS(NUM_LAYERS), .CODE_W(CODE_W)) regfile_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wr_layer_i  (cfg_layer_i),
    .wr_code_i   (cfg_code_i),
    .busy_i      (busy_o),
    .act_v_i     (act_v),
    .act_layer_i (act_layer),
    .xfer_end_i  (xfer_end),
    .codes_o     (codes_w),
    .order_err_o (order_err_o)
  );

  txlvl_pick #(.NUM_LAYERS(NUM_LAYERS), .CODE_W(CODE_W), .IDX_W(IDX_W)) pick_i (
    .codes_i     (codes_w),
    .layer_i     (req_layer_i),
    .bcast_i     (req_bcast_i),
    .level_o     (pick_level),
    .err_o       (pick_err),
    .src_v_o     (pick_src_v),
    .src_layer_o (pick_src)
  );

  txlvl_hold #(.NUM_LAYERS(NUM_LAYERS), .CODE_W(CODE_W)) hold_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_start_i),
    .xfer_end_i   (xfer_end),
    .pick_level_i (pick_level),
    .pick_err_i   (pick_err),
    .pick_src_v_i (pick_src_v),
    .pick_src_i   (pick_src),
    .busy_o       (busy_o),
    .level_o      (level_o),
    .idx_err_o    (idx_err_o),
    .act_v_o      (act_v),
    .act_layer_o  (act_layer)
  );
endmodule

// File: rtl/txlvl_sel_chk.sv
module txlvl_sel_chk #(
  parameter int NUM_LAYERS = 4,
  parameter int CODE_W     = 4,
  parameter int IDX_W      = 3,
  localparam int LSEL_W    = $clog2(NUM_LAYERS),
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}}
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              req_start_i,
  input logic [IDX_W-1:0]                  req_layer_i,
  input logic                              req_bcast_i,
  input logic                              req_end_i,
  input logic [CODE_W-1:0]                 level_o,
  input logic                              busy_o,
  input logic                              idx_err_o,
  input logic [NUM_LAYERS-1:0][CODE_W-1:0] codes_i
);
  // R2
  layer_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_start_i && !busy_o && !req_bcast_i && int'(req_layer_i) < NUM_LAYERS)
    |=> (busy_o && level_o == $past(codes_i[req_layer_i[LSEL_W-1:0]]) && !idx_err_o));

  // R3
  bcast_far_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_start_i && !busy_o && req_bcast_i)
    |=> (level_o == $past(codes_i[NUM_LAYERS-1]) && !idx_err_o));

  // R4
  oor_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_start_i && !busy_o && !req_bcast_i && int'(req_layer_i) >= NUM_LAYERS)
    |=> (level_o == MAX_CODE && idx_err_o));

  // R5
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_end_i) |=> (busy_o && $stable(level_o) && $stable(idx_err_o)));

  // R6
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (level_o == '0 && !idx_err_o));

  // R6
  end_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_end_i) |=> !busy_o);
endmodule

bind txlvl_sel txlvl_sel_chk #(
  .NUM_LAYERS(NUM_LAYERS), .CODE_W(CODE_W), .IDX_W(IDX_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_start_i (req_start_i),
  .req_layer_i (req_layer_i),
  .req_bcast_i (req_bcast_i),
  .req_end_i   (req_end_i),
  .level_o     (level_o),
  .busy_o      (busy_o),
  .idx_err_o   (idx_err_o),
  .codes_i     (codes_w)
);

// File: tb/txlvl_sel_tb_top.sv
module txlvl_sel_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_layer_i = '0;
  logic [3:0] cfg_code_i = '0;
  logic       req_start_i = 1'b0;
  logic [2:0] req_layer_i = '0;
  logic       req_bcast_i = 1'b0;
  logic       req_end_i = 1'b0;
  logic [3:0] level_o;
  logic       busy_o;
  logic       idx_err_o;
  logic       order_err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int mdl [4];

  typedef struct {
    int    lvl;
    int    err;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  txlvl_sel dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_layer_i, .cfg_code_i,
    .req_start_i, .req_layer_i, .req_bcast_i, .req_end_i,
    .level_o, .busy_o, .idx_err_o, .order_err_o
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // monitor: pop the expected level when a transfer appears, watch it stay put
  logic prev_busy = 1'b0;
  exp_t cur;
  bit   moved = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o && !prev_busy) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: got transfer level %0d expected no transfer", level_o);
        end else begin
          cur = exp_q.pop_front();
          chk({cur.tag, " level"}, int'(level_o), cur.lvl);
          chk({cur.tag, " idx_err"}, int'(idx_err_o), cur.err);
          moved = 1'b0;
        end
      end else if (busy_o && prev_busy) begin
        if (int'(level_o) != cur.lvl) moved = 1'b1;
      end else if (!busy_o && prev_busy) begin
        chk("R5 level held through burst", int'(moved), 0);
      end
      prev_busy <= busy_o;
    end
  end

  task automatic wr(int layer, int code);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_layer_i = 2'(layer); cfg_code_i = 4'(code);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    mdl[layer] = code;
  endtask

  task automatic begin_xfer(int layer, bit bc, string tag);
    exp_t e;
    @(negedge clk_i);
    req_start_i = 1'b1; req_layer_i = 3'(layer); req_bcast_i = bc;
    if (bc) begin e.lvl = mdl[3]; e.err = 0; end
    else if (layer > 3) begin e.lvl = 15; e.err = 1; end
    else begin e.lvl = mdl[layer]; e.err = 0; end
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
    req_start_i = 1'b0; req_bcast_i = 1'b0;
  endtask

  task automatic end_xfer();
    req_end_i = 1'b1;
    @(negedge clk_i);
    req_end_i = 1'b0;
    chk("R6 busy after end", int'(busy_o), 0);
    chk("R6 level off after end", int'(level_o), 0);
  endtask

  task automatic do_xfer(int layer, bit bc, int len, string tag);
    begin_xfer(layer, bc, tag);
    repeat (len - 1) @(negedge clk_i);
    end_xfer();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 15;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 level", int'(level_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 idx_err", int'(idx_err_o), 0);
    chk("R1 order_err", int'(order_err_o), 0);
    rst_ni = 1'b1;
    do_xfer(2, 1'b0, 2, "R1 reset code");

    wr(0, 2); wr(1, 5); wr(2, 9); wr(3, 12);
    chk("R7 rising codes", int'(order_err_o), 0);

    // R2 per-layer levels
    do_xfer(0, 1'b0, 1, "R2 layer0");
    do_xfer(1, 1'b0, 3, "R2 layer1");
    do_xfer(2, 1'b0, 2, "R2 layer2");
    do_xfer(3, 1'b0, 4, "R2 layer3");
    // R3 broadcast
    do_xfer(0, 1'b1, 2, "R3 bcast idx0");
    do_xfer(6, 1'b1, 2, "R3 bcast idx6");
    // R4 bad index
    do_xfer(4, 1'b0, 2, "R4 idx4");
    do_xfer(7, 1'b0, 3, "R4 idx7");

    // R5 start during burst ignored
    begin_xfer(0, 1'b0, "R5 layer0");
    req_start_i = 1'b1; req_layer_i = 3'd3;
    @(negedge clk_i);
    req_start_i = 1'b0;
    chk("R5 level after stray start", int'(level_o), 2);
    @(negedge clk_i);
    end_xfer();
    @(negedge clk_i);
    chk("R5 no restart", int'(busy_o), 0);

    // R7 order check
    wr(2, 4);
    chk("R7 falling neighbour", int'(order_err_o), 1);
    wr(2, 12);
    chk("R7 equal neighbours", int'(order_err_o), 0);

    // R8 write to another layer during burst applies at once
    begin_xfer(1, 1'b0, "R8 layer1");
    cfg_we_i = 1'b1; cfg_layer_i = 2'd3; cfg_code_i = 4'd1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R8 immediate write", int'(order_err_o), 1);
    cfg_we_i = 1'b1; cfg_code_i = 4'd12;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R8 immediate restore", int'(order_err_o), 0);
    end_xfer();

    // R9 write to active layer deferred, last wins
    begin_xfer(1, 1'b0, "R9 layer1");
    cfg_we_i = 1'b1; cfg_layer_i = 2'd1; cfg_code_i = 4'd13;
    @(negedge clk_i);
    cfg_code_i = 4'd14;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R9 deferred during burst", int'(order_err_o), 0);
    end_xfer();
    chk("R9 applied at end", int'(order_err_o), 1);
    mdl[1] = 14;
    do_xfer(1, 1'b0, 2, "R9 last write wins");
    wr(1, 5);

    // R9 write on the end cycle
    begin_xfer(2, 1'b0, "R9 layer2");
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_layer_i = 2'd2; cfg_code_i = 4'd3;
    end_xfer();
    cfg_we_i = 1'b0;
    chk("R9 end-cycle write applied", int'(order_err_o), 1);
    mdl[2] = 3;
    do_xfer(2, 1'b0, 2, "R9 end-cycle value");

    repeat (3) @(negedge clk_i);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule